// File: doc/BRIEF.md
# Single-Precision Significand Rounding Core

This block is a purely combinational rounding stage for a floating-point datapath. It takes a sign bit, a signed exponent, a wide significand with its leading bit at the top, three extra guard, round and sticky bits left over from any earlier denormalising right shift, and a 2-bit rounding mode. It reduces the significand to its kept width (24 bits by default, from 53). It returns the adjusted exponent and significand together with two indications: whether the kept part was incremented, and whether any discarded bit was nonzero.

The caller decides which operands are sent here and packs the result into a register format. When the increment carries out of the kept field, the core renormalises the significand to a leading one and raises the exponent by one. The caller therefore never sees an unnormalised result. Widths are parameters, so the same core serves narrower formats and small test configurations.

Top module: `sp_round_core`

## Requirements
- R1: The kept field is sig_i[SIG_W-1 -: KEEP_W], so its least significant bit is sig_i[SIG_W-KEEP_W]. The guard bit is sig_i[SIG_W-KEEP_W-1] and the round bit is sig_i[SIG_W-KEEP_W-2]. The sticky bit is the OR of every lower significand bit and of the three ext_grx_i bits. With the defaults, the kept field is sig_i[52:29], guard is sig_i[28] and round is sig_i[27].
- R2: With mode_i = 2'b00 (nearest), the kept field is incremented when guard is 1 and at least one of LSB, round or sticky is 1.
- R3: With mode_i = 2'b01 (toward zero), the kept field is never incremented.
- R4: With mode_i = 2'b10 (toward plus infinity), the kept field is incremented exactly when sign_i is 0 and any of guard, round or sticky is 1.
- R5: With mode_i = 2'b11 (toward minus infinity), the kept field is incremented exactly when sign_i is 1 and any of guard, round or sticky is 1.
- R6: If the increment carries out of the kept field, the kept field of sig_o becomes a 1 followed by zeros, and exp_o becomes exp_i + 1.
- R7: All bits of sig_o below the kept field are 0.
- R8: fr_o equals the increment decision. fi_o equals guard OR round OR sticky.
- R9: exp_o equals exp_i when there is no carry-out. The exponent is an EXP_W-bit two's-complement value, and the +1 wraps modulo 2^EXP_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the operand, 1 = negative |
| exp_i | input | EXP_W | Two's-complement unbiased exponent |
| sig_i | input | SIG_W | Significand, leading bit at SIG_W-1 |
| ext_grx_i | input | 3 | Guard, round, sticky from earlier denormalisation, all folded into sticky |
| mode_i | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| exp_o | output | EXP_W | Adjusted exponent |
| sig_o | output | SIG_W | Rounded significand, low SIG_W-KEEP_W bits zero |
| fr_o | output | 1 | Kept field was incremented |
| fi_o | output | 1 | Some discarded bit was nonzero |

## Verification
The bench builds a second copy of the core with SIG_W = 8, KEEP_W = 4 and EXP_W = 6. That narrow copy is swept over every significand, sign, mode and external-bit combination. The sweep therefore covers every tie, every all-ones kept field that carries out, and every case where only the external bits make the result inexact. Alternating exponents include the maximum positive value, which exercises the two's-complement wrap. A short directed set on the default 53/24/13 copy confirms the bit positions at full width.

// File: rtl/sp_round_pkg.sv
package sp_round_pkg;
   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_ZERO    = 2'b01,
      RM_POS_INF = 2'b10,
      RM_NEG_INF = 2'b11
   } round_mode_e;

   typedef struct packed {
      logic lsb;
      logic guard;
      logic rnd;
      logic sticky;
   } round_bits_t;
endpackage

// File: rtl/sp_round_sticky.sv
module sp_round_sticky
   import sp_round_pkg::*;
#(
   parameter int SIG_W  = 53,
   parameter int KEEP_W = 24
) (
   input  logic [SIG_W-1:0] sig_i,
   input  logic [2:0]       ext_i,
   output round_bits_t      bits_o
);
   localparam int LSB_POS = SIG_W - KEEP_W;
   localparam int G_POS   = LSB_POS - 1;
   localparam int R_POS   = G_POS - 1;
   localparam int TAIL_W  = R_POS;

   logic tail_or;

   generate
      if (TAIL_W > 0) begin : g_tail
         assign tail_or = |sig_i[TAIL_W-1:0];
      end else begin : g_no_tail
         assign tail_or = 1'b0;
      end
   endgenerate

   always_comb begin
      bits_o.lsb    = sig_i[LSB_POS];
      bits_o.guard  = sig_i[G_POS];
      bits_o.rnd    = sig_i[R_POS];
      bits_o.sticky = tail_or | (|ext_i);
   end
endmodule

// File: rtl/sp_round_decide.sv
module sp_round_decide
   import sp_round_pkg::*;
(
   input  logic [1:0]  mode_i,
   input  logic        sign_i,
   input  round_bits_t bits_i,
   output logic        inc_o,
   output logic        inexact_o
);
   round_mode_e mode;

   always_comb begin
      mode      = round_mode_e'(mode_i);
      inexact_o = bits_i.guard | bits_i.rnd | bits_i.sticky;
      unique case (mode)
         RM_NEAREST: inc_o = bits_i.guard & (bits_i.lsb | bits_i.rnd | bits_i.sticky);
         RM_ZERO:    inc_o = 1'b0;
         RM_POS_INF: inc_o = ~sign_i & inexact_o;
         RM_NEG_INF: inc_o = sign_i & inexact_o;
         default:    inc_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/sp_round_incr.sv
module sp_round_incr #(
   parameter int KEEP_W = 24,
   parameter int EXP_W  = 13
) (
   input  logic [KEEP_W-1:0] kept_i,
   input  logic              inc_i,
   input  logic [EXP_W-1:0]  exp_i,
   output logic [KEEP_W-1:0] kept_o,
   output logic [EXP_W-1:0]  exp_o
);
   localparam logic [KEEP_W-1:0] NORM_ONE = {1'b1, {(KEEP_W-1){1'b0}}};

   logic [KEEP_W:0] sum;

   always_comb begin
      sum = {1'b0, kept_i} + {{KEEP_W{1'b0}}, inc_i};
      if (sum[KEEP_W]) begin
         kept_o = NORM_ONE;
         exp_o  = exp_i + {{(EXP_W-1){1'b0}}, 1'b1};
      end else begin
         kept_o = sum[KEEP_W-1:0];
         exp_o  = exp_i;
      end
   end
endmodule

// File: rtl/sp_round_core.sv
module sp_round_core
   import sp_round_pkg::*;
#(
   parameter int SIG_W  = 53,
   parameter int KEEP_W = 24,
   parameter int EXP_W  = 13
) (
   input  logic             sign_i,
   input  logic [EXP_W-1:0] exp_i,
   input  logic [SIG_W-1:0] sig_i,
   input  logic [2:0]       ext_grx_i,
   input  logic [1:0]       mode_i,
   output logic [EXP_W-1:0] exp_o,
   output logic [SIG_W-1:0] sig_o,
   output logic             fr_o,
   output logic             fi_o
);
   localparam int DROP_W = SIG_W - KEEP_W;

   generate
      if (KEEP_W < 2) begin : g_bad_keep
         $error("sp_round_core: KEEP_W must be at least 2");
      end
      if (DROP_W < 2) begin : g_bad_drop
         $error("sp_round_core: SIG_W must exceed KEEP_W by at least 2");
      end
      if (EXP_W < 2) begin : g_bad_exp
         $error("sp_round_core: EXP_W must be at least 2");
      end
   endgenerate

   round_bits_t       rbits;
   logic              inc;
   logic [KEEP_W-1:0] kept_new;

   sp_round_sticky #(.SIG_W(SIG_W), .KEEP_W(KEEP_W)) u_sticky (
      .sig_i  (sig_i),
      .ext_i  (ext_grx_i),
      .bits_o (rbits)
   );

   sp_round_decide u_decide (
      .mode_i    (mode_i),
      .sign_i    (sign_i),
      .bits_i    (rbits),
      .inc_o     (inc),
      .inexact_o (fi_o)
   );

   sp_round_incr #(.KEEP_W(KEEP_W), .EXP_W(EXP_W)) u_incr (
      .kept_i (sig_i[SIG_W-1 -: KEEP_W]),
      .inc_i  (inc),
      .exp_i  (exp_i),
      .kept_o (kept_new),
      .exp_o  (exp_o)
   );

   assign fr_o  = inc;
   assign sig_o = {kept_new, {DROP_W{1'b0}}};
endmodule

// File: rtl/sp_round_checker.sv
module sp_round_checker #(
   parameter int SIG_W  = 53,
   parameter int KEEP_W = 24,
   parameter int EXP_W  = 13
) (
   input logic             sign_i,
   input logic [EXP_W-1:0] exp_i,
   input logic [SIG_W-1:0] sig_i,
   input logic [1:0]       mode_i,
   input logic [EXP_W-1:0] exp_o,
   input logic [SIG_W-1:0] sig_o,
   input logic             fr_o,
   input logic             fi_o
);
   localparam int DROP_W = SIG_W - KEEP_W;
   localparam logic [KEEP_W-1:0] NORM_ONE = {1'b1, {(KEEP_W-1){1'b0}}};

   always_comb begin
      assert_rz_no_inc_R3: assert (!(mode_i == 2'b01 && fr_o));
      assert_pos_sign_R4: assert (!(mode_i == 2'b10 && sign_i && fr_o));
      assert_neg_sign_R5: assert (!(mode_i == 2'b11 && !sign_i && fr_o));
      assert_carry_norm_R6: assert (exp_o == exp_i || sig_o[SIG_W-1 -: KEEP_W] == NORM_ONE);
      assert_tail_clear_R7: assert (sig_o[DROP_W-1:0] == '0);
      assert_exact_no_inc_R8: assert (fi_o || (!fr_o && sig_o[SIG_W-1 -: KEEP_W] == sig_i[SIG_W-1 -: KEEP_W]));
      assert_exp_step_R9: assert (exp_o == exp_i || (fr_o && exp_o == exp_i + {{(EXP_W-1){1'b0}}, 1'b1}));
   end
endmodule

bind sp_round_core sp_round_checker #(.SIG_W(SIG_W), .KEEP_W(KEEP_W), .EXP_W(EXP_W)) u_chk (
   .sign_i (sign_i),
   .exp_i  (exp_i),
   .sig_i  (sig_i),
   .mode_i (mode_i),
   .exp_o  (exp_o),
   .sig_o  (sig_o),
   .fr_o   (fr_o),
   .fi_o   (fi_o)
);

// File: tb/tb_sp_round_core.sv
module tb_sp_round_core;
   localparam int SW = 8, KW = 4, EW = 6;
   localparam int DSW = 53, DKW = 24, DEW = 13;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   // narrow configuration, swept exhaustively
   logic          s_sign;
   logic [EW-1:0] s_exp, s_exp_o;
   logic [SW-1:0] s_sig, s_sig_o;
   logic [2:0]    s_ext;
   logic [1:0]    s_mode;
   logic          s_fr, s_fi;

   sp_round_core #(.SIG_W(SW), .KEEP_W(KW), .EXP_W(EW)) dut (
      .sign_i(s_sign), .exp_i(s_exp), .sig_i(s_sig), .ext_grx_i(s_ext), .mode_i(s_mode),
      .exp_o(s_exp_o), .sig_o(s_sig_o), .fr_o(s_fr), .fi_o(s_fi)
   );

   // default configuration, directed cases
   logic           d_sign;
   logic [DEW-1:0] d_exp, d_exp_o;
   logic [DSW-1:0] d_sig, d_sig_o;
   logic [2:0]     d_ext;
   logic [1:0]     d_mode;
   logic           d_fr, d_fi;

   sp_round_core dut_dflt (
      .sign_i(d_sign), .exp_i(d_exp), .sig_i(d_sig), .ext_grx_i(d_ext), .mode_i(d_mode),
      .exp_o(d_exp_o), .sig_o(d_sig_o), .fr_o(d_fr), .fi_o(d_fi)
   );

   // arithmetic reference: value comparison of the discarded part against one half
   function automatic void model(input logic [63:0] sig, input int sw, input int kw,
                                 input logic sign, input logic [2:0] ext, input logic [1:0] mode,
                                 output logic [63:0] sig_x, output logic inc, output logic inex,
                                 output logic carry);
      logic [63:0] kept, rem, half, nk;
      logic above, tie;
      kept  = sig >> (sw - kw);
      rem   = sig & ((64'd1 << (sw - kw)) - 64'd1);
      half  = 64'd1 << (sw - kw - 1);
      above = (rem > half) || (rem == half && ext != 3'b000);
      tie   = (rem == half) && (ext == 3'b000);
      inex  = (rem != 64'd0) || (ext != 3'b000);
      case (mode)
         2'b00:   inc = above || (tie && kept[0]);
         2'b01:   inc = 1'b0;
         2'b10:   inc = !sign && inex;
         default: inc = sign && inex;
      endcase
      nk    = kept + {63'd0, inc};
      carry = (nk == (64'd1 << kw));
      if (carry) nk = 64'd1 << (kw - 1);
      sig_x = nk << (sw - kw);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic string mode_req(input logic [1:0] m);
      case (m)
         2'b00:   return "R2";
         2'b01:   return "R3";
         2'b10:   return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic run_small(input logic [SW-1:0] sig, input logic sign, input logic [2:0] ext,
                            input logic [1:0] mode, input logic [EW-1:0] e);
      logic [63:0] sx; logic inc, inex, carry;
      logic [EW-1:0] ex;
      @(posedge clk);
      s_sig = sig; s_sign = sign; s_ext = ext; s_mode = mode; s_exp = e;
      @(negedge clk);
      model({56'd0, sig}, SW, KW, sign, ext, mode, sx, inc, inex, carry);
      ex = carry ? e + 1'b1 : e;
      check(s_fr == inc, mode_req(mode), {63'd0, s_fr}, {63'd0, inc});
      check(s_sig_o == sx[SW-1:0], carry ? "R6" : mode_req(mode), {56'd0, s_sig_o}, sx);
      check(s_fi == inex, "R8", {63'd0, s_fi}, {63'd0, inex});
      check(s_exp_o == ex, carry ? "R6" : "R9", {58'd0, s_exp_o}, {58'd0, ex});
      check(s_sig_o[SW-KW-1:0] == '0, "R7", {56'd0, s_sig_o}, sx);
   endtask

   task automatic run_dflt(input logic [DSW-1:0] sig, input logic sign, input logic [2:0] ext,
                           input logic [1:0] mode, input logic [DEW-1:0] e, input string req);
      logic [63:0] sx; logic inc, inex, carry;
      logic [DEW-1:0] ex;
      @(posedge clk);
      d_sig = sig; d_sign = sign; d_ext = ext; d_mode = mode; d_exp = e;
      @(negedge clk);
      model({11'd0, sig}, DSW, DKW, sign, ext, mode, sx, inc, inex, carry);
      ex = carry ? e + 1'b1 : e;
      check(d_fr == inc && d_fi == inex, req, {62'd0, d_fr, d_fi}, {62'd0, inc, inex});
      check(d_sig_o == sx[DSW-1:0] && d_exp_o == ex, req, {11'd0, d_sig_o}, sx);
   endtask

   initial begin
      s_sig = '0; s_sign = 0; s_ext = 0; s_mode = 0; s_exp = '0;
      d_sig = '0; d_sign = 0; d_ext = 0; d_mode = 0; d_exp = '0;
      @(negedge clk);
      // exact zero input: no rounding flags (R8)
      check(s_fr == 1'b0 && s_fi == 1'b0 && s_sig_o == '0, "R8", {62'd0, s_fr, s_fi}, 64'd0);

      // full sweep of the narrow configuration; exponent 31 reaches the wrap (R9)
      for (int s = 0; s < (1 << SW); s++)
         for (int m = 0; m < 4; m++)
            for (int sg = 0; sg < 2; sg++)
               for (int x = 0; x < 8; x++)
                  run_small(s[SW-1:0], sg[0], x[2:0], m[1:0], (x[0] ? 6'd31 : 6'd58));

      // default widths: R1 bit positions
      run_dflt({1'b1, 23'd0, 1'b1, 28'd0}, 1'b0, 3'b000, 2'b00, 13'd5, "R1");   // tie, even: hold
      run_dflt({1'b1, 22'd0, 1'b1, 1'b1, 28'd0}, 1'b0, 3'b000, 2'b00, 13'd5, "R1"); // tie, odd: up
      run_dflt({1'b1, 23'd0, 1'b0, 1'b1, 27'd0}, 1'b0, 3'b000, 2'b10, 13'd0, "R1"); // round bit only
      run_dflt({1'b1, 52'd0}, 1'b1, 3'b001, 2'b11, 13'h1FFF, "R1");               // external bit only
      run_dflt({24'hFFFFFF, 1'b1, 28'd0}, 1'b0, 3'b000, 2'b00, 13'd127, "R6");    // carry-out
      run_dflt({24'hFFFFFF, 29'h1FFFFFFF}, 1'b0, 3'b111, 2'b01, 13'd127, "R3");   // toward zero
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule